// File: doc/BRIEF.md
# Interrupt Status and Aggregation Unit

This unit holds interrupt state for a set of bus-controller channels and folds them onto a single interrupt line. Each channel owns an event enable register and an event status register. One-cycle event pulses from the channel's command engine set bits in its status register. A flag per channel in a read-only global register records that the channel has enabled events pending. The shared interrupt output is the OR of those flags.

Software clears status bits by writing ones to them. When a clear write empties a channel's status, that channel's global flag drops. Status is filtered against the enable mask only at the moment events are raised, and not continuously. The unit also restarts reception: if software acknowledges a set receive-done bit while the engine still reports a receive request, the unit pulses a restart strobe back to that engine.

Register access uses a plain write strobe with address and data. Read data is a combinational function of the address and the current register state.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every enable register, every status register and every global flag reads zero, and `irq` is low.
- R2: The address is decoded as follows. Bit 0 selects the enable register (0) or the status register (1). Bits CH_AW:1 give the channel, and the top address bit set selects the global register. A write to an enable register stores wdata[EVT_W-1:0] at the clock edge, and the register reads back zero-extended in those bit positions. The event bit positions are: 0 transmit acknowledged, 1 transmit not acknowledged, 2 receive done, 3 arbitration lost, 4 normal stop, 5 abnormal condition, 6 clock-line timeout, 13 recovery done, 14 data-line timeout.
- R3: In a cycle where a channel receives any event pulse, its next status is (status with the cleared bits removed, OR the events) AND the enable value held before that edge. If that result is nonzero, the channel's global flag is set.
- R4: If a raise leaves the filtered status at zero, the channel's global flag keeps its previous value, whether that value was set or clear.
- R5: A write to a status register clears each bit written as one. If the result is zero and no nonzero raise happens in the same cycle, the channel's global flag is cleared. This holds even if the status was already zero.
- R6: An event pulse and a clear write to the same bit in the same cycle leave that bit set, provided it is enabled.
- R7: `irq` is high exactly when at least one global flag is set. A channel clearing its flag does not lower `irq` while another channel's flag is set.
- R8: The channel's `rx_kick` bit is high for exactly one cycle, in the cycle after the edge at which all of the following hold: a status write to that channel has wdata bit 2 set, its status bit 2 was set, and its `rx_req` is high. Otherwise `rx_kick` stays low.
- R9: The global register reads the flag of channel c at bit c, with zeros above. Writes to it change no register.
- R10: A channel index at or above NUM_CH reads zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address (CH_AW+2 bits) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` |
| evt | input | NUM_CH*EVT_W | Event pulses, channel c in bits c*EVT_W +: EVT_W |
| rx_req | input | NUM_CH | Receive request still pending, per channel |
| rx_kick | output | NUM_CH | Receive restart strobe, per channel |
| irq | output | 1 | Shared interrupt output |

## Verification
The bench builds the unit with five channels, 15 event bits and 16 data bits. Five is not a power of two, so the three-bit channel field has three unused codes. That makes the read-zero and write-ignore behaviour of missing channels reachable, and the global register needs more than four flag bits. With the data width one bit wider than the event width, the top data bit is exercised: it is dropped on enable writes and reads back zero. Random traffic across the whole address space, including the global register, runs alongside directed cases. The directed cases cover a raise filtered to zero, same-cycle event and clear, clearing an already empty channel, and a receive restart with and without a pending request.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
   localparam int RX_DONE_BIT = 2;

   typedef enum logic {
      REG_ENABLE = 1'b0,
      REG_STATUS = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/irqagg_chan.sv
module irqagg_chan
   import irqagg_pkg::*;
#(
   parameter int EVT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_hit,
   input  reg_sel_e         sel,
   input  logic [EVT_W-1:0] wdata,
   input  logic [EVT_W-1:0] evt,
   input  logic             rx_req,
   output logic [EVT_W-1:0] en_q,
   output logic [EVT_W-1:0] st_q,
   output logic             gbit_q,
   output logic             kick_q
);
   logic             en_w, clr_w, raise;
   logic [EVT_W-1:0] clr_mask, st_kept, st_nxt;

   always_comb begin
      en_w     = wr_hit && (sel == REG_ENABLE);
      clr_w    = wr_hit && (sel == REG_STATUS);
      clr_mask = clr_w ? wdata : '0;
      st_kept  = (st_q & ~clr_mask) | evt;
      raise    = |evt;
      st_nxt   = raise ? (st_kept & en_q) : st_kept;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         st_q   <= '0;
         gbit_q <= 1'b0;
         kick_q <= 1'b0;
      end else begin
         if (en_w) en_q <= wdata;
         st_q <= st_nxt;
         if (raise && (|st_nxt))
            gbit_q <= 1'b1;
         else if (clr_w && (st_nxt == '0))
            gbit_q <= 1'b0;
         kick_q <= clr_w && wdata[RX_DONE_BIT] && st_q[RX_DONE_BIT] && rx_req;
      end
   end

   AST_MASK_AFTER_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((st_q & ~$past(en_q)) == '0)); // R3

   AST_EVT_SETS_GBIT: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt & en_q)) |=> gbit_q); // R3

   AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_w && (evt == '0) && ((st_q & ~wdata) == '0)) |=> !gbit_q); // R5

   AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt & en_q)) |=> ((st_q & $past(evt & en_q)) == $past(evt & en_q))); // R6

   AST_KICK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      kick_q |-> $past(clr_w && wdata[RX_DONE_BIT] && st_q[RX_DONE_BIT] && rx_req)); // R8
endmodule

// File: rtl/irqagg_rdmux.sv
module irqagg_rdmux #(
   parameter int NUM_CH = 4,
   parameter int EVT_W  = 15,
   parameter int DATA_W = 16,
   parameter int CH_AW  = 2
) (
   input  logic                    glb_sel,
   input  logic [CH_AW-1:0]        ch_idx,
   input  logic                    st_sel,
   input  logic [NUM_CH*EVT_W-1:0] en_all,
   input  logic [NUM_CH*EVT_W-1:0] st_all,
   input  logic [NUM_CH-1:0]       gbits,
   output logic [DATA_W-1:0]       rdata
);
   always_comb begin
      rdata = '0;
      if (glb_sel) begin
         rdata = DATA_W'(gbits);
      end else begin
         for (int c = 0; c < NUM_CH; c++) begin
            if (ch_idx == CH_AW'(c))
               rdata = st_sel ? DATA_W'(st_all[c*EVT_W +: EVT_W])
                              : DATA_W'(en_all[c*EVT_W +: EVT_W]);
         end
      end
   end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irqagg_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int EVT_W  = 15,
   parameter int DATA_W = 16,
   localparam int CH_AW  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int ADDR_W = CH_AW + 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [DATA_W-1:0]       wdata,
   output logic [DATA_W-1:0]       rdata,
   input  logic [NUM_CH*EVT_W-1:0] evt,
   input  logic [NUM_CH-1:0]       rx_req,
   output logic [NUM_CH-1:0]       rx_kick,
   output logic                    irq
);
   if (EVT_W <= RX_DONE_BIT) begin : g_bad_evt
      $error("EVT_W must cover the receive-done bit");
   end
   if (DATA_W < EVT_W || DATA_W < NUM_CH) begin : g_bad_data
      $error("DATA_W must hold EVT_W and NUM_CH bits");
   end
   if (DATA_W > EVT_W) begin : g_hi
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^wdata[DATA_W-1:EVT_W];
   end

   logic                    glb_sel, st_sel;
   logic [CH_AW-1:0]        ch_idx;
   reg_sel_e                sel;
   logic [NUM_CH*EVT_W-1:0] en_all, st_all;
   logic [NUM_CH-1:0]       gbits;

   assign glb_sel = addr[ADDR_W-1];
   assign ch_idx  = addr[CH_AW:1];
   assign st_sel  = addr[0];
   assign sel     = reg_sel_e'(addr[0]);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit;
      assign hit = wr_en && !glb_sel && (ch_idx == CH_AW'(c));
      irqagg_chan #(.EVT_W(EVT_W)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_hit (hit),
         .sel    (sel),
         .wdata  (wdata[EVT_W-1:0]),
         .evt    (evt[c*EVT_W +: EVT_W]),
         .rx_req (rx_req[c]),
         .en_q   (en_all[c*EVT_W +: EVT_W]),
         .st_q   (st_all[c*EVT_W +: EVT_W]),
         .gbit_q (gbits[c]),
         .kick_q (rx_kick[c])
      );
   end

   irqagg_rdmux #(
      .NUM_CH(NUM_CH), .EVT_W(EVT_W), .DATA_W(DATA_W), .CH_AW(CH_AW)
   ) u_rdmux (
      .glb_sel (glb_sel),
      .ch_idx  (ch_idx),
      .st_sel  (st_sel),
      .en_all  (en_all),
      .st_all  (st_all),
      .gbits   (gbits),
      .rdata   (rdata)
   );

   assign irq = |gbits;

   AST_GLB_WRITE_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && glb_sel && (evt == '0)) |=> (gbits == $past(gbits))); // R9
endmodule

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
   localparam int NCH = 5;
   localparam int EW  = 15;
   localparam int DW  = 16;
   localparam int CAW = 3;
   localparam int AW  = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [AW-1:0]   addr = '0;
   logic [DW-1:0]   wdata = '0;
   logic [DW-1:0]   rdata;
   logic [NCH*EW-1:0] evt = '0;
   logic [NCH-1:0]  rx_req = '0;
   logic [NCH-1:0]  rx_kick;
   logic            irq;

   always #2 clk = ~clk;

   irq_aggregator #(.NUM_CH(NCH), .EVT_W(EW), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .evt(evt), .rx_req(rx_req), .rx_kick(rx_kick), .irq(irq)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic [EW-1:0]  m_en [NCH];
   logic [EW-1:0]  m_st [NCH];
   logic [NCH-1:0] m_gb;
   logic [NCH-1:0] m_kick;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [AW-1:0] a_of(input int ch, input logic s);
      return {1'b0, ch[CAW-1:0], s};
   endfunction

   localparam logic [AW-1:0] A_GLB = {1'b1, {(AW-1){1'b0}}};

   function automatic logic [DW-1:0] m_read(input logic [AW-1:0] a);
      int ch;
      ch = int'(a[CAW:1]);
      if (a[AW-1]) return DW'(m_gb);
      if (ch >= NCH) return '0;
      return a[0] ? DW'(m_st[ch]) : DW'(m_en[ch]);
   endfunction

   function automatic string tag_of(input logic [AW-1:0] a);
      if (a[AW-1]) return "R9";
      if (int'(a[CAW:1]) >= NCH) return "R10";
      return a[0] ? "R3" : "R2";
   endfunction

   task automatic cycle();
      @(posedge clk);
      for (int c = 0; c < NCH; c++) begin
         logic hit, clrw, enw, raise;
         logic [EW-1:0] ev, nst;
         hit   = wr_en && !addr[AW-1] && (int'(addr[CAW:1]) == c);
         clrw  = hit && addr[0];
         enw   = hit && !addr[0];
         ev    = evt[c*EW +: EW];
         raise = |ev;
         nst   = (m_st[c] & ~(clrw ? wdata[EW-1:0] : '0)) | ev;
         if (raise) nst = nst & m_en[c];
         m_kick[c] = clrw && wdata[2] && m_st[c][2] && rx_req[c];
         if (raise && nst != '0) m_gb[c] = 1'b1;
         else if (clrw && nst == '0) m_gb[c] = 1'b0;
         m_st[c] = nst;
         if (enw) m_en[c] = wdata[EW-1:0];
      end
      @(negedge clk);
      chk("R7", 32'(irq), 32'(|m_gb));
      chk("R8", 32'(rx_kick), 32'(m_kick));
      chk(tag_of(addr), 32'(rdata), 32'(m_read(addr)));
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      cycle();
      wr_en = 1'b0;
   endtask

   task automatic ev(input int ch, input logic [EW-1:0] b);
      evt[ch*EW +: EW] = b;
      cycle();
      evt = '0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      wr_en = 1'b0; addr = a;
      #1 d = rdata;
   endtask

   initial begin
      #800000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [DW-1:0] d;
      void'($urandom(32'd4711));
      for (int c = 0; c < NCH; c++) begin m_en[c] = '0; m_st[c] = '0; end
      m_gb = '0; m_kick = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int c = 0; c < NCH; c++) begin
         rd(a_of(c, 1'b0), d); chk("R1", 32'(d), 0);
         rd(a_of(c, 1'b1), d); chk("R1", 32'(d), 0);
      end
      rd(A_GLB, d); chk("R1", 32'(d), 0);
      chk("R1", 32'(irq), 0);
      @(negedge clk);

      // R2 enable write keeps low EW bits
      wr(a_of(1, 1'b0), 16'hFFFF);
      rd(a_of(1, 1'b0), d); chk("R2", 32'(d), 32'h7FFF);

      // R3 raise with tx-ack and rx-done
      ev(1, 15'h0005);
      rd(a_of(1, 1'b1), d); chk("R3", 32'(d), 32'h0005);
      rd(A_GLB, d); chk("R3", 32'(d), 32'h02);
      chk("R7", 32'(irq), 1);

      // R4 filtered-to-zero raise keeps a clear flag clear
      wr(a_of(2, 1'b0), 16'h0001);
      ev(2, 15'h0002);
      rd(a_of(2, 1'b1), d); chk("R4", 32'(d), 0);
      rd(A_GLB, d); chk("R4", 32'(d), 32'h02);
      ev(2, 15'h0001);
      wr(a_of(2, 1'b0), 16'h0002);
      ev(2, 15'h0001);
      rd(a_of(2, 1'b1), d); chk("R4", 32'(d), 0);
      rd(A_GLB, d); chk("R4", 32'(d), 32'h06);

      // R5 partial and full clears
      wr(a_of(1, 1'b1), 16'h0001);
      rd(a_of(1, 1'b1), d); chk("R5", 32'(d), 32'h0004);
      rd(A_GLB, d); chk("R5", 32'(d), 32'h06);
      wr(a_of(1, 1'b1), 16'h0004);
      rd(A_GLB, d); chk("R5", 32'(d), 32'h04);
      chk("R7", 32'(irq), 1);
      wr(a_of(2, 1'b1), 16'h0000);
      rd(A_GLB, d); chk("R5", 32'(d), 0);
      chk("R7", 32'(irq), 0);

      // R8 receive restart
      ev(1, 15'h0004);
      rx_req = 5'b00010;
      wr(a_of(1, 1'b1), 16'h0004);
      chk("R8", 32'(rx_kick), 32'h02);
      cycle();
      chk("R8", 32'(rx_kick), 0);
      ev(1, 15'h0004);
      rx_req = '0;
      wr(a_of(1, 1'b1), 16'h0004);
      chk("R8", 32'(rx_kick), 0);

      // R6 event beats clear on the same bit
      wr(a_of(3, 1'b0), 16'h7FFF);
      ev(3, 15'h0040);
      wr_en = 1'b1; addr = a_of(3, 1'b1); wdata = 16'h0040;
      evt[3*EW +: EW] = 15'h0040;
      cycle();
      wr_en = 1'b0; evt = '0;
      rd(a_of(3, 1'b1), d); chk("R6", 32'(d), 32'h0040);
      rd(A_GLB, d); chk("R6", 32'(d), 32'h08);

      // R9 global write ignored, R10 missing channel
      wr(A_GLB, 16'h0000);
      rd(A_GLB, d); chk("R9", 32'(d), 32'h08);
      wr(a_of(6, 1'b0), 16'h1234);
      rd(a_of(6, 1'b0), d); chk("R10", 32'(d), 0);
      rd(a_of(3, 1'b0), d); chk("R10", 32'(d), 32'h7FFF);

      // random traffic
      for (int i = 0; i < 4000; i++) begin
         for (int c = 0; c < NCH; c++)
            evt[c*EW +: EW] = (($urandom % 4) == 0) ? 15'($urandom) : '0;
         rx_req = NCH'($urandom);
         wr_en  = (($urandom % 3) == 0);
         addr   = AW'($urandom);
         wdata  = DW'($urandom);
         cycle();
      end
      evt = '0; wr_en = 1'b0;

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule